// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands one bit per clock. Both operands sit in shift registers that can be loaded in parallel. While a run is in progress, both registers move one place toward the least significant end on every clock. The two bits leaving the bottom of the registers go into a single full adder together with a stored carry. The sum bit enters the top of the first operand register, so that register slowly turns into the result while it is still supplying operand bits. The carry out of each step is kept in a flip-flop until the next step.

A parallel load puts new operands in place and clears the stored carry. A one-cycle start pulse then runs exactly `WIDTH` shift steps and raises a done flag. When the flag is high, the first register holds the low bits of the sum and the carry flip-flop holds the bit above them. A start pulse does not clear the carry, so a second run adds that carry as a carry-in. The second register either rotates its own bottom bit back to the top, which keeps operand B intact, or takes its top bits from a serial input pin.

Top module: `bitserial_adder`

## Requirements
- R1: While reset is asserted, and after reset is released, the A register, the B register, the carry and done all read zero.
- R2: When `load_i` is high at a clock edge, A takes `a_par_i`, B takes `b_par_i`, and both the carry and done become 0 after that edge.
- R3: Load takes priority over start and over a run in progress. A load stops the run. A start that arrives in the same cycle as a load is ignored, and no shifting follows it.
- R4: A start pulse taken while idle causes exactly `WIDTH` shift steps, on the `WIDTH` edges that follow the start edge. Done rises on the last of those edges. At that point {carry, A} equals A + B + the carry held before the run.
- R5: Start does not clear the carry. After a run, a second start without a load adds the stored carry as a carry-in.
- R6: With `b_keep_i` = 1, B moves its bit 0 into its top bit on each step, so B holds its loaded value after a full run.
- R7: With `b_keep_i` = 0, the top bit of B takes `b_ser_i` on each step. The result of the addition is unchanged by this.
- R8: A start that arrives during a run is ignored. When no run is active and no load is given, A, B and the carry keep their values.
- R9: Done stays high until the next load or the next accepted start, and it is low whenever a run is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Parallel load of both operands; clears the carry |
| start_i | input | 1 | Begins a run of WIDTH shift steps |
| b_keep_i | input | 1 | 1: B rotates its bit 0 to the top; 0: B takes its top bit from b_ser_i |
| b_ser_i | input | 1 | Serial input for the top of B when b_keep_i is 0 |
| a_par_i | input | WIDTH | Parallel value for operand A |
| b_par_i | input | WIDTH | Parallel value for operand B |
| a_q_o | output | WIDTH | Contents of A; the sum once done is high |
| b_q_o | output | WIDTH | Contents of B |
| carry_o | output | 1 | Stored carry; the final carry out once done is high |
| done_o | output | 1 | High after a run completes |

## Verification
The assertions assume that the controls are synchronous to `clk` and are stable at each rising edge. They also assume that a run is started only from a register pair that has been loaded or that has finished an earlier run. The timing checks assume that `start_i` is a single-cycle pulse. The bench changes every input only on falling edges. It holds `b_ser_i` and `b_keep_i` fixed for the length of each run. It gives a start pulse during a run, and a start together with a load, only in the tests written to show that these cases are ignored.

// File: rtl/bitserial_adder_pkg.sv
// Shared definitions for the bit-serial adder.
// Assumes: nothing beyond standard SystemVerilog.
package bitserial_adder_pkg;

    localparam int unsigned SADD_DEF_W = 4;

    // Source of the bit that enters the top of the B register on a shift step
    typedef enum logic {
        BTOP_FROM_PIN = 1'b0,
        BTOP_ROTATE   = 1'b1
    } btop_src_e;

endpackage

// File: rtl/sadd_shreg.sv
// Register with parallel load and a right shift. The serial bit enters the MSB.
// Assumes: load and shift are synchronous; load wins when both are high.
module sadd_shreg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] par_i,
    input  logic         ser_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_r;

    // Storage: reset clears, load replaces the contents, shift moves toward the LSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (load_i) begin
            q_r <= par_i;
        end else if (shift_i) begin
            q_r <= {ser_i, q_r[W-1:1]};
        end
    end

    assign q_o = q_r;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(q_o));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(par_i)));

endmodule

// File: rtl/sadd_fa_carry.sv
// Full adder on the two operand LSBs, with the stored carry between steps.
// Assumes: clr_i and step_i come from the controller; clr_i wins.
module sadd_fa_carry (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    input  logic a_bit_i,
    input  logic b_bit_i,
    output logic sum_o,
    output logic carry_o
);

    logic carry_r;
    logic cout;

    // Combinational full adder on the current bits and the stored carry
    always_comb begin
        sum_o = a_bit_i ^ b_bit_i ^ carry_r;
        cout  = (a_bit_i & b_bit_i) | (carry_r & (a_bit_i ^ b_bit_i));
    end

    // Carry flip-flop: cleared by reset or load, updated on each shift step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_r <= 1'b0;
        end else if (clr_i) begin
            carry_r <= 1'b0;
        end else if (step_i) begin
            carry_r <= cout;
        end
    end

    assign carry_o = carry_r;

    // R2
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !carry_o);

    // R5
    carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !step_i) |=> $stable(carry_o));

endmodule

// File: rtl/sadd_ctrl.sv
// Controller: one start pulse gives W shift steps, then done rises.
// Assumes: load aborts a run; start is ignored during a run or together with load.
module sadd_ctrl #(
    parameter int unsigned W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic start_i,
    output logic shift_o,
    output logic done_o
);

    localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    // Sequencing: load clears, a run counts W steps, an idle start begins a run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end else if (start_i) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end
    end

    assign shift_o = busy_q;
    assign done_o  = done_q;

    // R3
    load_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!shift_o && !done_o));

    // R4
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(shift_o));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_o && done_o));

    // R8
    run_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o && !load_i && cnt_q != LAST) |=> shift_o);

endmodule

// File: rtl/bitserial_adder.sv
// Bit-serial adder top: A and B shift registers, a full adder with its carry
// flip-flop, and the step controller. The sum is written back into the MSB of A.
// Assumes: operands are unsigned; b_keep_i and b_ser_i are held for a whole run.
module bitserial_adder
    import bitserial_adder_pkg::*;
#(
    parameter int unsigned WIDTH = SADD_DEF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             start_i,
    input  logic             b_keep_i,
    input  logic             b_ser_i,
    input  logic [WIDTH-1:0] a_par_i,
    input  logic [WIDTH-1:0] b_par_i,
    output logic [WIDTH-1:0] a_q_o,
    output logic [WIDTH-1:0] b_q_o,
    output logic             carry_o,
    output logic             done_o
);

    logic      step;
    logic      sum_bit;
    logic      b_top;
    btop_src_e b_src;

    // Choose what enters the top of B: its own LSB or the serial pin
    always_comb begin
        b_src = btop_src_e'(b_keep_i);
        b_top = (b_src == BTOP_ROTATE) ? b_q_o[0] : b_ser_i;
    end

    sadd_ctrl #(.W(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .start_i (start_i),
        .shift_o (step),
        .done_o  (done_o)
    );

    sadd_shreg #(.W(WIDTH)) u_reg_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .shift_i (step),
        .par_i   (a_par_i),
        .ser_i   (sum_bit),
        .q_o     (a_q_o)
    );

    sadd_shreg #(.W(WIDTH)) u_reg_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .shift_i (step),
        .par_i   (b_par_i),
        .ser_i   (b_top),
        .q_o     (b_q_o)
    );

    sadd_fa_carry u_fa (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (load_i),
        .step_i  (step),
        .a_bit_i (a_q_o[0]),
        .b_bit_i (b_q_o[0]),
        .sum_o   (sum_bit),
        .carry_o (carry_o)
    );

    // R6
    b_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_i && b_keep_i) |=> (b_q_o[WIDTH-1] == $past(b_q_o[0])));

    // R7
    b_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_i && !b_keep_i) |=> (b_q_o[WIDTH-1] == $past(b_ser_i)));

endmodule

// File: tb/test_bitserial_adder.sv
// Directed bench for the bit-serial adder; one task per scenario.
module test_bitserial_adder;

    localparam int W = 4;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic         start_i = 1'b0;
    logic         b_keep_i = 1'b1;
    logic         b_ser_i = 1'b0;
    logic [W-1:0] a_par_i = '0;
    logic [W-1:0] b_par_i = '0;
    logic [W-1:0] a_q_o;
    logic [W-1:0] b_q_o;
    logic         carry_o;
    logic         done_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitserial_adder #(.WIDTH(W)) i_bitserial_adder (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
        .b_keep_i(b_keep_i), .b_ser_i(b_ser_i), .a_par_i(a_par_i),
        .b_par_i(b_par_i), .a_q_o(a_q_o), .b_q_o(b_q_o),
        .carry_o(carry_o), .done_o(done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input int a, input int b);
        a_par_i = W'(a);
        b_par_i = W'(b);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_n(2);
        chk("R1 A in reset", int'(a_q_o), 0);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 A", int'(a_q_o), 0);
        chk("R1 B", int'(b_q_o), 0);
        chk("R1 carry", int'(carry_o), 0);
        chk("R1 done", int'(done_o), 0);
    endtask

    task automatic t_load();
        do_load(9, 6);
        chk("R2 A", int'(a_q_o), 9);
        chk("R2 B", int'(b_q_o), 6);
        chk("R2 carry", int'(carry_o), 0);
        chk("R2 done", int'(done_o), 0);
    endtask

    task automatic t_sweep();
        b_keep_i = 1'b1;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                do_load(a, b);
                do_start();
                wait_n(W - 1);
                if (a == 0 && b == 0) chk("R4 done not early", int'(done_o), 0);
                wait_n(1);
                chk("R4 done", int'(done_o), 1);
                chk("R4 sum", int'({carry_o, a_q_o}), a + b);
                chk("R6 B kept", int'(b_q_o), b);
            end
        end
    endtask

    task automatic t_chain();
        b_keep_i = 1'b1;
        do_load(15, 1);
        do_start();
        wait_n(W);
        chk("R5 first A", int'(a_q_o), 0);
        chk("R5 first carry", int'(carry_o), 1);
        do_start();
        wait_n(W);
        chk("R5 chained A", int'(a_q_o), 2);
        chk("R5 chained carry", int'(carry_o), 0);
    endtask

    task automatic t_fill();
        b_keep_i = 1'b0;
        b_ser_i = 1'b0;
        do_load(5, 10);
        do_start();
        wait_n(W);
        chk("R7 sum zero fill", int'({carry_o, a_q_o}), 15);
        chk("R7 B zero fill", int'(b_q_o), 0);
        b_ser_i = 1'b1;
        do_load(3, 3);
        do_start();
        wait_n(W);
        chk("R7 sum ones fill", int'({carry_o, a_q_o}), 6);
        chk("R7 B ones fill", int'(b_q_o), 15);
        b_ser_i = 1'b0;
        b_keep_i = 1'b1;
    endtask

    task automatic t_priority();
        do_load(15, 15);
        do_start();
        wait_n(2);
        a_par_i = W'(6);
        b_par_i = W'(2);
        load_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        start_i = 1'b0;
        chk("R3 A after abort", int'(a_q_o), 6);
        chk("R3 B after abort", int'(b_q_o), 2);
        chk("R3 carry after abort", int'(carry_o), 0);
        chk("R3 done after abort", int'(done_o), 0);
        wait_n(W + 2);
        chk("R3 A no run", int'(a_q_o), 6);
        chk("R3 done no run", int'(done_o), 0);
    endtask

    task automatic t_busy_start();
        do_load(7, 5);
        do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_n(W - 2);
        chk("R8 done on time", int'(done_o), 1);
        chk("R8 sum", int'({carry_o, a_q_o}), 12);
        wait_n(3);
        chk("R8 A idle hold", int'(a_q_o), 12);
        chk("R8 B idle hold", int'(b_q_o), 5);
        chk("R9 done held", int'(done_o), 1);
        do_start();
        chk("R9 done cleared by start", int'(done_o), 0);
        wait_n(W);
        chk("R9 second run A", int'(a_q_o), 1);
        chk("R9 second run carry", int'(carry_o), 1);
        do_load(0, 0);
        chk("R9 done cleared by load", int'(done_o), 0);
    endtask

    initial begin
        wait_n(2);
        t_reset();
        t_load();
        t_sweep();
        t_chain();
        t_fill();
        t_priority();
        t_busy_start();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule